// File: doc/BRIEF.md
# Quantized Outer-Product Multiply-Accumulate Array

This block is a grid of N rows by M columns of signed 8-bit dot-product cells. Every clock cycle it can take one activation vector and one weight vector and form their outer product: each cell multiplies K pairs of 8-bit operands, sums the K products, and adds the sum into its own 32-bit accumulator. With the default N=8, M=8, K=4, the array performs 256 multiply-accumulates per cycle.

The weight vector is wide and spread across the columns. Column c takes its own K-lane slice, and every cell in that column sees the same slice. The activation vector carries one K-lane slice per row, one batch per row, arranged in transposed order so that each row is a separate batch. Two controls steer each step. A clear input zeroes all accumulators. An accumulate-enable input adds the new dot products. When both are high, each accumulator is loaded with its new dot product directly.

Results are read out one row per cycle through a registered, row-selected port that is M accumulators wide. Fetching operands from memory and requantizing results are handled outside this block.

Top module: `opa_mac_array`

## Requirements
- R1: While rst_n is low, and after it is released, every accumulator is zero and rd_data is zero.
- R2: Cell (r,c) uses the signed dot product of activation lanes act_vec[(r*K+k)*8 +: 8] and weight lanes wgt_vec[(c*K+k)*8 +: 8] for k = 0..K-1. Operands are two's complement, and each product is sign-extended to 32 bits before the sum.
- R3: A clock edge with acc_en=1 and acc_clr=0 adds each cell's dot product to its accumulator.
- R4: A clock edge with acc_clr=1 and acc_en=0 sets every accumulator to zero.
- R5: A clock edge with acc_clr=1 and acc_en=1 loads each accumulator with its new dot product, discarding the old value.
- R6: A clock edge with acc_clr=0 and acc_en=0 leaves every accumulator unchanged, whatever the operand inputs carry.
- R7: Accumulators wrap modulo 2^32 on overflow.
- R8: One cycle after an edge that samples rd_row, lane c of rd_data (bits c*32 +: 32) holds accumulator (rd_row, c) as it stood before that edge. rd_row must be below N.
- R9: New operands are taken every cycle. The sum of back-to-back steps with different operands appears in the accumulators one edge after the last step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_clr | input | 1 | Zero the accumulators (loads the dot product when acc_en is also high) |
| acc_en | input | 1 | Add this cycle's dot products |
| act_vec | input | N*K*8 | Activation lanes, one K-lane slice per row (batch) |
| wgt_vec | input | M*K*8 | Weight lanes, one K-lane slice per column, shared by every cell in that column |
| rd_row | input | max(1,clog2(N)) | Row selected for readout |
| rd_data | output | M*32 | Registered accumulators of the selected row, column c in lane c |

## Verification
The assertions assume that rd_row is always a valid row index and that the controls carry known values once reset is released. The bench drives rd_row only from 0 to N-1. It holds acc_en and acc_clr low during reset and during every readout sweep, so each readout observes a frozen accumulator state. The random operands cover the full signed 8-bit range, and a long all-minus-128 run pushes the accumulators through a 32-bit wrap.

// File: rtl/opa_pkg.sv
package opa_pkg;
   localparam int OPND_W = 8;
   localparam int PROD_W = 2 * OPND_W;
   localparam int ACC_W  = 32;

   typedef logic signed [ACC_W-1:0] acc_t;

   function automatic acc_t widen_prod(input logic signed [PROD_W-1:0] p);
      return {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
   endfunction
endpackage

// File: rtl/opa_dot_reduce.sv
module opa_dot_reduce
   import opa_pkg::*;
#(
   parameter int K    = 4,
   parameter bit TREE = 1'b1
) (
   input  logic [K*OPND_W-1:0] lane_a,
   input  logic [K*OPND_W-1:0] lane_b,
   output acc_t                dot
);
   localparam int KP = 2 ** $clog2(K);

   if (K < 1) begin : g_bad_k
      $error("opa_dot_reduce: K must be at least 1");
   end

   acc_t term [K];

   for (genvar i = 0; i < K; i++) begin : g_mul
      logic signed [PROD_W-1:0] prod;
      assign prod    = $signed(lane_a[i*OPND_W +: OPND_W]) * $signed(lane_b[i*OPND_W +: OPND_W]);
      assign term[i] = widen_prod(prod);
   end

   if (TREE) begin : g_tree
      acc_t node [2*KP-1];
      for (genvar l = 0; l < KP; l++) begin : g_leaf
         if (l < K) begin : g_used
            assign node[KP-1+l] = term[l];
         end else begin : g_pad
            assign node[KP-1+l] = '0;
         end
      end
      for (genvar n = 0; n < KP-1; n++) begin : g_node
         assign node[n] = node[2*n+1] + node[2*n+2];
      end
      assign dot = node[0];
   end else begin : g_chain
      acc_t part [K+1];
      assign part[0] = '0;
      for (genvar i = 0; i < K; i++) begin : g_step
         assign part[i+1] = part[i] + term[i];
      end
      assign dot = part[K];
   end
endmodule

// File: rtl/opa_cell.sv
module opa_cell
   import opa_pkg::*;
#(
   parameter int K    = 4,
   parameter bit TREE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                en,
   input  logic [K*OPND_W-1:0] act,
   input  logic [K*OPND_W-1:0] wgt,
   output acc_t                acc
);
   acc_t dot;

   opa_dot_reduce #(.K(K), .TREE(TREE)) u_reduce (
      .lane_a (act),
      .lane_b (wgt),
      .dot    (dot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         acc <= '0;
      else if (clr && en) acc <= dot;
      else if (clr)       acc <= '0;
      else if (en)        acc <= acc + dot;
   end

   // R3 and R7: wrapping add of the step's dot product
   a_r3_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr) |=> (acc == acc_t'($past(acc) + $past(dot))));
   a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !en) |=> (acc == '0));
   a_r5_load_dot: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && en) |=> (acc == $past(dot)));
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !en) |=> $stable(acc));
endmodule

// File: rtl/opa_readout.sv
module opa_readout
   import opa_pkg::*;
#(
   parameter int N   = 8,
   parameter int M   = 8,
   parameter int RSW = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N*M*ACC_W-1:0] acc_flat,
   input  logic [RSW-1:0]       rd_row,
   output logic [M*ACC_W-1:0]   rd_data
);
   localparam int ROW_W = M * ACC_W;

   logic [ROW_W-1:0] row_bus [N];
   logic [ROW_W-1:0] sel_bus;

   for (genvar r = 0; r < N; r++) begin : g_row
      assign row_bus[r] = acc_flat[r*ROW_W +: ROW_W];
   end

   always_comb begin
      sel_bus = '0;
      for (int r = 0; r < N; r++) begin
         if (int'(rd_row) == r) sel_bus = row_bus[r];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= sel_bus;
   end

   a_r8_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rd_row) < N);
   a_r1_reset_readout: assert property (@(posedge clk)
      !rst_n |=> (rd_data == '0) || rst_n);
endmodule

// File: rtl/opa_mac_array.sv
module opa_mac_array
   import opa_pkg::*;
#(
   parameter int N    = 8,
   parameter int M    = 8,
   parameter int K    = 4,
   parameter bit TREE = 1'b1,
   localparam int RSW = (N > 1) ? $clog2(N) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   acc_clr,
   input  logic                   acc_en,
   input  logic [N*K*OPND_W-1:0]  act_vec,
   input  logic [M*K*OPND_W-1:0]  wgt_vec,
   input  logic [RSW-1:0]         rd_row,
   output logic [M*ACC_W-1:0]     rd_data
);
   localparam int SLICE_W = K * OPND_W;
   localparam int CELLS   = N * M;

   if (N < 1 || M < 1) begin : g_bad_dim
      $error("opa_mac_array: N and M must be at least 1");
   end
   if (CELLS * K > 4096) begin : g_bad_size
      $error("opa_mac_array: array exceeds supported multiplier count");
   end

   logic [CELLS*ACC_W-1:0] acc_flat;

   for (genvar r = 0; r < N; r++) begin : g_r
      for (genvar c = 0; c < M; c++) begin : g_c
         acc_t cell_acc;
         opa_cell #(.K(K), .TREE(TREE)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (acc_clr),
            .en    (acc_en),
            .act   (act_vec[r*SLICE_W +: SLICE_W]),
            .wgt   (wgt_vec[c*SLICE_W +: SLICE_W]),
            .acc   (cell_acc)
         );
         assign acc_flat[(r*M+c)*ACC_W +: ACC_W] = cell_acc;
      end
   end

   opa_readout #(.N(N), .M(M), .RSW(RSW)) u_readout (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_flat (acc_flat),
      .rd_row   (rd_row),
      .rd_data  (rd_data)
   );

   a_r1_zero_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (acc_flat == '0));
endmodule

// File: tb/opa_mac_array_bench.sv
`timescale 1ns/1ps
module opa_mac_array_bench;
   localparam int N = 8;
   localparam int M = 8;
   localparam int K = 4;
   localparam int RSW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_clr = 1'b0;
   logic acc_en = 1'b0;
   logic [N*K*8-1:0] act_vec = '0;
   logic [M*K*8-1:0] wgt_vec = '0;
   logic [RSW-1:0]   rd_row = '0;
   logic [M*32-1:0]  rd_data;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic signed [7:0]  av [N][K];
   logic signed [7:0]  wv [M][K];
   logic signed [31:0] mdl [N][M];

   always #4 clk = ~clk;

   opa_mac_array #(.N(N), .M(M), .K(K)) u_opa_mac_array (
      .clk(clk), .rst_n(rst_n), .acc_clr(acc_clr), .acc_en(acc_en),
      .act_vec(act_vec), .wgt_vec(wgt_vec), .rd_row(rd_row), .rd_data(rd_data)
   );

   function automatic logic signed [31:0] dotf(int r, int c);
      logic signed [31:0] s = 0;
      for (int k = 0; k < K; k++) s += 32'(av[r][k]) * 32'(wv[c][k]);
      return s;
   endfunction

   task automatic pack_ops();
      for (int r = 0; r < N; r++)
         for (int k = 0; k < K; k++) act_vec[(r*K+k)*8 +: 8] = av[r][k];
      for (int c = 0; c < M; c++)
         for (int k = 0; k < K; k++) wgt_vec[(c*K+k)*8 +: 8] = wv[c][k];
   endtask

   task automatic rand_ops();
      for (int r = 0; r < N; r++)
         for (int k = 0; k < K; k++) av[r][k] = 8'($urandom);
      for (int c = 0; c < M; c++)
         for (int k = 0; k < K; k++) wv[c][k] = 8'($urandom);
   endtask

   task automatic fill_ops(logic signed [7:0] a, logic signed [7:0] w);
      for (int r = 0; r < N; r++) for (int k = 0; k < K; k++) av[r][k] = a;
      for (int c = 0; c < M; c++) for (int k = 0; k < K; k++) wv[c][k] = w;
   endtask

   // one control step; model updated at the capturing edge
   task automatic step(bit en, bit clr);
      @(negedge clk);
      pack_ops();
      acc_en = en;
      acc_clr = clr;
      @(posedge clk);
      for (int r = 0; r < N; r++)
         for (int c = 0; c < M; c++) begin
            if (clr && en)  mdl[r][c] = dotf(r, c);
            else if (clr)   mdl[r][c] = 0;
            else if (en)    mdl[r][c] = mdl[r][c] + dotf(r, c);
         end
   endtask

   task automatic readout_check(string tag);
      @(negedge clk);
      acc_en = 1'b0;
      acc_clr = 1'b0;
      for (int r = 0; r < N; r++) begin
         @(negedge clk);
         rd_row = RSW'(r);
         @(posedge clk);
         @(negedge clk);
         for (int c = 0; c < M; c++) begin
            checks++;
            if (rd_data[c*32 +: 32] !== mdl[r][c]) begin
               failures++;
               $display("FAIL %s row %0d col %0d actual=%0d expected=%0d", tag, r, c,
                        $signed(rd_data[c*32 +: 32]), mdl[r][c]);
            end
         end
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_0417));
      for (int r = 0; r < N; r++) for (int c = 0; c < M; c++) mdl[r][c] = 0;
      fill_ops(0, 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (rd_data !== '0) begin
         failures++;
         $display("FAIL R1 reset readout actual=%0h expected=0", rd_data);
      end
      rst_n = 1'b1;
      readout_check("R1 post-reset");

      // R5: clear with enable loads the dot product directly
      rand_ops();
      step(1'b1, 1'b0);
      rand_ops();
      step(1'b1, 1'b1);
      readout_check("R5 load");
      // R3: accumulate on top
      rand_ops();
      step(1'b1, 1'b0);
      readout_check("R3 accumulate");
      // R6: operands change but controls are idle
      rand_ops();
      step(1'b0, 1'b0);
      rand_ops();
      step(1'b0, 1'b0);
      readout_check("R6 hold");
      // R4: clear alone
      rand_ops();
      step(1'b0, 1'b1);
      readout_check("R4 clear");
      // R2: extremes of the signed range, sign-extended products
      fill_ops(-128, 127);
      av[0][0] = -1; wv[M-1][K-1] = -128; av[N-1][1] = 127;
      step(1'b1, 1'b1);
      readout_check("R2 signed extremes");

      // R9 and R2: back-to-back random steps with mixed controls
      for (int round = 0; round < 6; round++) begin
         for (int s = 0; s < 200; s++) begin
            int pick;
            rand_ops();
            pick = int'($urandom_range(0, 9));
            step(pick < 7, pick == 7 || pick == 8);
         end
         readout_check("R9 random stream");
      end

      // R7: long all -128 accumulation wraps past 2^31
      fill_ops(-128, -128);
      step(1'b1, 1'b1);
      @(negedge clk);
      pack_ops();
      acc_en = 1'b1;
      acc_clr = 1'b0;
      repeat (33000) @(posedge clk);
      for (int r = 0; r < N; r++)
         for (int c = 0; c < M; c++) mdl[r][c] = mdl[r][c] + 32'(33000) * dotf(r, c);
      readout_check("R7 wrap");
      checks++;
      if (mdl[0][0] >= 0) begin
         failures++;
         $display("FAIL R7 model did not wrap actual=%0d expected=negative", mdl[0][0]);
      end

      // R8: rows read back in reverse order
      rand_ops();
      step(1'b1, 1'b1);
      @(negedge clk);
      acc_en = 1'b0;
      acc_clr = 1'b0;
      for (int r = N - 1; r >= 0; r--) begin
         @(negedge clk);
         rd_row = RSW'(r);
         @(posedge clk);
         @(negedge clk);
         checks++;
         if (rd_data[(M-1)*32 +: 32] !== mdl[r][M-1]) begin
            failures++;
            $display("FAIL R8 row %0d actual=%0d expected=%0d", r,
                     $signed(rd_data[(M-1)*32 +: 32]), mdl[r][M-1]);
         end
      end

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule